// File: doc/BRIEF.md
# Infrared Mark-Width Frame Decoder

The decoder takes an already demodulated, active-low infrared line and turns it into data words. The line is synchronised with two flops. A divider makes a one-clock enable pulse every 0.1 ms from the 50 MHz system clock. A saturating counter measures how long each low period (a mark) lasts, counted in those 0.1 ms units. At the end of each mark the measured width falls into one of three bands: a long framing mark, a medium mark that carries a one, or a short mark that carries a zero. Any other width falls into none of them.

A framing mark opens a frame. The next twelve data marks are shifted in, least significant bit first. When the last bit is accepted, the word is written to the output and a strobe is raised for one clock. A width outside every band ends the frame early. A silence of more than 5 ms inside a frame also ends it. In both cases no strobe is produced. A synchronous enable, when low, holds the divider at zero and forces the decoder back to idle.

Top module: `ir_mark_decoder`

## Requirements
- R1: After a synchronous reset, data_valid is 0 and data_out is all zeros, and the decoder waits for a framing mark.
- R2: The 0.1 ms unit is one clock-wide pulse every TICK_DIV clocks (default 5000 at 50 MHz). All mark widths and silences are measured in these units.
- R3: ir_n is active low (0 = mark). It passes through two synchroniser flops. For the final bit of a frame, data_valid is high in the third clock after the clock edge that first samples ir_n high.
- R4: A measured width of 22 to 28 units is a framing mark, 10 to 14 units is a one, and 4 to 8 units is a zero. All bounds are inclusive.
- R5: After a framing mark, 12 data marks are taken. The first data mark received lands in data_out bit 0 and the last in bit 11. data_out changes only when the twelfth bit is accepted.
- R6: Data marks that arrive while no framing mark has opened a frame have no effect. No strobe is produced and data_out is unchanged.
- R7: Inside a frame, a mark whose width is in neither data band ends the frame without a strobe. Later data marks are then ignored.
- R8: The width counter saturates at 31 units. A mark held long enough to wrap a 5-bit count (for example 57 units) is never taken as a framing mark.
- R9: Inside a frame, if the line stays idle for 50 units, the frame ends without a strobe. A silence of 40 units does not end it.
- R10: data_valid is high for exactly one clock per accepted word.
- R11: When en is sampled low, the divider is held at zero, the decoder returns to idle and no strobe is raised, even in the cycle in which the twelfth bit would have been accepted. data_out keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Synchronous enable; low holds the decoder idle |
| ir_n | input | 1 | Demodulated infrared line, low during a mark |
| data_out | output | BITS | Last complete word, bit 0 received first |
| data_valid | output | 1 | One-clock strobe when data_out is updated |

## Verification
Two events can fall in the same clock: acceptance of the twelfth bit and the synchronous enable being taken away. The bench provokes this by releasing the line at the end of the final data mark and dropping en exactly at the clock edge that would register the word. That edge is two clocks after the first synchronised sample of the release. A correct decoder gives no strobe and keeps the previous data_out, and it decodes the next full frame normally once en returns. The same release timing, with en kept high, pins the strobe to the third clock after the line is first sampled high.

// File: rtl/ir_mark_decoder.sv
module ir_mark_decoder #(
  parameter int TICK_DIV      = 5000,
  parameter int BITS          = 12,
  parameter int WCNT_W        = 5,
  parameter int START_MIN     = 22,
  parameter int START_MAX     = 28,
  parameter int ONE_MIN       = 10,
  parameter int ONE_MAX       = 14,
  parameter int ZERO_MIN      = 4,
  parameter int ZERO_MAX      = 8,
  parameter int TIMEOUT_TICKS = 50
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            ir_n,
  output logic [BITS-1:0] data_out,
  output logic            data_valid
);

  localparam int TDW = $clog2(TICK_DIV + 1);
  localparam int GW  = $clog2(TIMEOUT_TICKS + 1);
  localparam int BCW = $clog2(BITS + 1);
  localparam logic [TDW-1:0]    T_LAST = TDW'(TICK_DIV - 1);
  localparam logic [WCNT_W-1:0] W_MAX  = '1;
  localparam logic [WCNT_W-1:0] S_LO   = WCNT_W'(START_MIN);
  localparam logic [WCNT_W-1:0] S_HI   = WCNT_W'(START_MAX);
  localparam logic [WCNT_W-1:0] O_LO   = WCNT_W'(ONE_MIN);
  localparam logic [WCNT_W-1:0] O_HI   = WCNT_W'(ONE_MAX);
  localparam logic [WCNT_W-1:0] Z_LO   = WCNT_W'(ZERO_MIN);
  localparam logic [WCNT_W-1:0] Z_HI   = WCNT_W'(ZERO_MAX);
  localparam logic [GW-1:0]     G_LAST = GW'(TIMEOUT_TICKS - 1);
  localparam logic [BCW-1:0]    B_LAST = BCW'(BITS - 1);

  typedef enum logic {IDLE, FRAME} state_t;

  state_t            state;
  logic              s1, s2, mark_q;
  logic [TDW-1:0]    tcnt;
  logic [WCNT_W-1:0] wcnt;
  logic [GW-1:0]     gcnt;
  logic [BCW-1:0]    bcnt;
  logic [BITS-1:0]   shreg;

  wire tick      = en && (tcnt == T_LAST);
  wire mark      = ~s2;
  wire mark_rise = mark & ~mark_q;
  wire mark_end  = ~mark & mark_q;
  wire is_start  = (wcnt >= S_LO) && (wcnt <= S_HI);
  wire is_one    = (wcnt >= O_LO) && (wcnt <= O_HI);
  wire is_zero   = (wcnt >= Z_LO) && (wcnt <= Z_HI);
  wire [BITS-1:0] nxt = {is_one, shreg[BITS-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      s1     <= 1'b1;
      s2     <= 1'b1;
      mark_q <= 1'b0;
    end else begin
      s1     <= ir_n;
      s2     <= s1;
      mark_q <= mark;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en)  tcnt <= '0;
    else if (tick)   tcnt <= '0;
    else             tcnt <= tcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= IDLE;
      wcnt       <= '0;
      gcnt       <= '0;
      bcnt       <= '0;
      shreg      <= '0;
      data_out   <= '0;
      data_valid <= 1'b0;
    end else begin
      data_valid <= 1'b0;
      if (!en) begin
        state <= IDLE;
        wcnt  <= '0;
        gcnt  <= '0;
        bcnt  <= '0;
      end else begin
        if (mark_rise)                            wcnt <= '0;
        else if (mark && tick && wcnt != W_MAX)   wcnt <= wcnt + 1'b1;

        if (mark || state == IDLE) gcnt <= '0;
        else if (tick)             gcnt <= gcnt + 1'b1;

        if (mark_end) begin
          if (state == IDLE) begin
            if (is_start) begin
              state <= FRAME;
              bcnt  <= '0;
            end
          end else if (is_one || is_zero) begin
            shreg <= nxt;
            if (bcnt == B_LAST) begin
              data_out   <= nxt;
              data_valid <= 1'b1;
              state      <= IDLE;
            end else begin
              bcnt <= bcnt + 1'b1;
            end
          end else begin
            state <= IDLE;
          end
        end else if (state == FRAME && !mark && tick && gcnt == G_LAST) begin
          state <= IDLE;
        end
      end
    end
  end

  p_tick_single_r2: assert property (@(posedge clk) disable iff (rst)
    ((TICK_DIV > 1) && tick) |=> !tick);

  p_strobe_single_r10: assert property (@(posedge clk) disable iff (rst)
    data_valid |=> !data_valid);

  p_idle_no_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    (en && state == IDLE) |=> !data_valid);

  p_bad_width_abort_r7: assert property (@(posedge clk) disable iff (rst)
    (en && state == FRAME && mark_end && !is_one && !is_zero) |=> (state == IDLE && !data_valid));

  p_wcnt_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (en && mark && mark_q && wcnt == W_MAX) |=> (wcnt == W_MAX));

  p_timeout_r9: assert property (@(posedge clk) disable iff (rst)
    (en && state == FRAME && !mark && !mark_q && tick && gcnt == G_LAST) |=> (state == IDLE && !data_valid));

  p_disable_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !en |=> (state == IDLE && !data_valid && $stable(data_out)));

endmodule

// File: tb/test_ir_mark_decoder.sv
module test_ir_mark_decoder;
  localparam int DIV  = 4;
  localparam int BITS = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b1;
  logic ir_n = 1'b1;
  logic [BITS-1:0] data_out;
  logic data_valid;

  int checks = 0;
  int fails  = 0;
  int vcount = 0;
  logic [BITS-1:0] expq[$];
  logic prev_valid = 1'b0;

  always #4 clk = ~clk;

  ir_mark_decoder #(.TICK_DIV(DIV), .BITS(BITS)) i_ir_mark_decoder (
    .clk(clk), .rst(rst), .en(en), .ir_n(ir_n),
    .data_out(data_out), .data_valid(data_valid)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (data_valid) begin
        vcount++;
        check(!prev_valid, "R10 strobe width", 32'(prev_valid), 0);
        if (expq.size() == 0) begin
          check(1'b0, "R6/R7 unexpected strobe", 32'(data_out), 0);
        end else begin
          logic [BITS-1:0] e;
          e = expq.pop_front();
          check(data_out == e, "R5 word", 32'(data_out), 32'(e));
        end
      end
      prev_valid = data_valid;
    end
  end

  task automatic hold(input bit lvl, input int units);
    ir_n = lvl;
    repeat (units * DIV) @(negedge clk);
  endtask

  task automatic send_bits(input logic [BITS-1:0] w, input int n, input int first,
                           input int one_w, input int zero_w);
    for (int i = first; i < first + n; i++) begin
      hold(1'b0, w[i] ? one_w : zero_w);
      hold(1'b1, 6);
    end
  endtask

  task automatic send_frame_w(input logic [BITS-1:0] w, input int st, input int one_w, input int zero_w);
    expq.push_back(w);
    hold(1'b0, st);
    hold(1'b1, 6);
    send_bits(w, BITS, 0, one_w, zero_w);
  endtask

  task automatic send_frame(input logic [BITS-1:0] w);
    send_frame_w(w, 25, 12, 6);
  endtask

  task automatic expect_none(input int v0, input logic [BITS-1:0] d0, input string req);
    hold(1'b1, 10);
    check(vcount == v0, req, 32'(vcount), 32'(v0));
    check(data_out == d0, req, 32'(data_out), 32'(d0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int v0;
    logic [BITS-1:0] d0;
    repeat (5) @(negedge clk);
    check(data_valid == 1'b0, "R1 strobe at reset", 32'(data_valid), 0);
    check(data_out == '0, "R1 data at reset", 32'(data_out), 0);
    rst = 1'b0;
    hold(1'b1, 4);

    // R2 R4 R5: nominal widths
    send_frame(12'hA5C);
    send_frame(12'h001);
    send_frame(12'h800);
    hold(1'b1, 4);
    check(vcount == 3, "R5 frames decoded", 32'(vcount), 3);

    // R4: window edges, wide and narrow
    send_frame_w(12'h6B2, 28, 14, 8);
    send_frame_w(12'h94D, 23, 11, 5);
    hold(1'b1, 4);
    check(vcount == 5, "R4 window edges", 32'(vcount), 5);

    // R3: latency of the strobe after the final release
    expq.push_back(12'h3C3);
    hold(1'b0, 25); hold(1'b1, 6);
    send_bits(12'h3C3, BITS - 1, 0, 12, 6);
    hold(1'b0, 6);
    ir_n = 1'b1;
    @(negedge clk);
    check(data_valid == 1'b0, "R3 latency +1", 32'(data_valid), 0);
    @(negedge clk);
    check(data_valid == 1'b0, "R3 latency +2", 32'(data_valid), 0);
    @(negedge clk);
    check(data_valid == 1'b1, "R3 latency +3", 32'(data_valid), 1);
    check(data_out == 12'h3C3, "R3 word", 32'(data_out), 32'h3C3);
    hold(1'b1, 6);

    // R6: data marks with no framing mark
    v0 = vcount; d0 = data_out;
    send_bits(12'hFFF, BITS, 0, 12, 6);
    send_bits(12'h000, BITS, 0, 12, 6);
    expect_none(v0, d0, "R6 stray bits");
    send_frame(12'h155);

    // R7: out-of-band width mid frame
    v0 = vcount + 1; d0 = 12'h155;
    hold(1'b1, 4);
    v0 = vcount; d0 = data_out;
    hold(1'b0, 25); hold(1'b1, 6);
    send_bits(12'hABC, 5, 0, 12, 6);
    hold(1'b0, 17); hold(1'b1, 6);
    send_bits(12'hABC, 6, 6, 12, 6);
    expect_none(v0, d0, "R7 bad width");

    // R8: long hold that would wrap a 5-bit count into the framing band
    v0 = vcount; d0 = data_out;
    hold(1'b0, 57); hold(1'b1, 6);
    send_bits(12'h0F0, BITS, 0, 12, 6);
    expect_none(v0, d0, "R8 saturation");

    // R9: 60-unit silence aborts, 40-unit silence does not
    v0 = vcount; d0 = data_out;
    hold(1'b0, 25); hold(1'b1, 6);
    send_bits(12'h5A5, 4, 0, 12, 6);
    hold(1'b1, 60);
    send_bits(12'h5A5, 8, 4, 12, 6);
    expect_none(v0, d0, "R9 timeout");
    expq.push_back(12'h2E7);
    hold(1'b0, 25); hold(1'b1, 6);
    send_bits(12'h2E7, 4, 0, 12, 6);
    hold(1'b1, 40);
    send_bits(12'h2E7, 8, 4, 12, 6);
    hold(1'b1, 4);
    check(data_out == 12'h2E7, "R9 short silence kept", 32'(data_out), 32'h2E7);

    // R11: enable low mid frame
    v0 = vcount; d0 = data_out;
    hold(1'b0, 25); hold(1'b1, 6);
    send_bits(12'hC3A, 6, 0, 12, 6);
    en = 1'b0; hold(1'b1, 3); en = 1'b1;
    send_bits(12'hC3A, 6, 6, 12, 6);
    expect_none(v0, d0, "R11 enable low mid frame");

    // R11: enable drop in the cycle of the twelfth bit
    v0 = vcount; d0 = data_out;
    hold(1'b0, 25); hold(1'b1, 6);
    send_bits(12'h7E1, BITS - 1, 0, 12, 6);
    hold(1'b0, 6);
    ir_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check(data_valid == 1'b0, "R11 collision strobe", 32'(data_valid), 0);
    en = 1'b1;
    expect_none(v0, d0, "R11 collision data");
    send_frame(12'h7E1);
    hold(1'b1, 4);
    check(data_out == 12'h7E1, "R11 recovery", 32'(data_out), 32'h7E1);

    check(expq.size() == 0, "R5 all expected words seen", 32'(expq.size()), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule